// File: doc/BRIEF.md
# Stuffed NRZI Line Receiver

This receiver turns a single NRZI-coded, bit-stuffed serial line back into bytes. An internal divider produces a sampling tick once every four system clocks. On each tick the line is captured and compared with the previous capture. An unchanged level decodes as a one and a changed level decodes as a zero. While the receiver is idle, the line rests high. The first low sample marks the start bit. That sample is consumed and every later tick yields one decoded bit.

A run counter tracks consecutive decoded ones. After six of them, the following bit is the stuffed zero the transmitter inserted. The counter raises a pause for that bit, so it is neither shifted into the byte register nor counted. Accepted bits enter the shift register least-significant bit first. Every eighth accepted bit loads the byte output and pulses a one-clock valid strobe. The receiver stays in the receiving state until the next reset.

Top module: `lrx_deser`

## Requirements
- R1: While reset is asserted and after it is released, byte_o reads 0x00 and byte_valid_o is low until a byte has been assembled.
- R2: A line that stays high after reset produces no byte_valid_o pulse.
- R3: Reception starts at the first tick whose line sample is low. That start sample contributes no data bit.
- R4: After the start, each tick decodes one bit: 1 when the sample equals the previous sample, 0 when it differs.
- R5: Decoded bits are placed least-significant bit first. The first accepted bit of a byte becomes byte_o[0] and the eighth becomes byte_o[7].
- R6: The bit that follows six consecutive decoded ones is discarded. It is not stored and not counted, and the run count restarts after it.
- R7: byte_valid_o is high for exactly one clock after every eighth accepted bit. byte_o keeps its value until the next pulse.
- R8: The line is sampled once every four system clocks, so each symbol held for four clocks yields exactly one bit, whatever the phase of the symbol edges.
- R9: A zero that follows a run of five or fewer ones is kept as a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | NRZI serial line, idle high |
| byte_o | output | 8 | Last assembled byte |
| byte_valid_o | output | 1 | One-clock strobe when byte_o is updated |

## Verification
The assertions assume that line_i stays stable across each four-clock symbol window, so a tick never lands on a changing level. They also assume that the transmitter always stuffs a zero after six ones, and that the line rests high between reset and the start bit. The bench meets these assumptions by changing the line only on falling clock edges, and only once per four clocks. It does so by building each stream with its own reference encoder. That encoder inserts the stuffed zero and performs the NRZI toggling. Streams start at several clock phases relative to the internal divider.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  localparam int unsigned LRX_BYTE_W  = 8;
  localparam int unsigned LRX_RUN_LEN = 6;
  localparam int unsigned LRX_DIV     = 4;
endpackage

// File: rtl/lrx_tick_gen.sv
module lrx_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R8
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lrx_nrzi_dec.sv
module lrx_nrzi_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic newbit_o,
  output logic nrz_o
);
  logic active_q, prev_q, newbit_q, nrz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      prev_q   <= 1'b1;
      newbit_q <= 1'b0;
      nrz_q    <= 1'b0;
    end else begin
      newbit_q <= 1'b0;
      if (tick_i) begin
        prev_q <= line_i;
        if (active_q) begin
          newbit_q <= 1'b1;
          nrz_q    <= (line_i == prev_q);
        end else if (!line_i) begin
          active_q <= 1'b1;  // start bit consumed
        end
      end
    end
  end

  assign newbit_o = newbit_q;
  assign nrz_o    = nrz_q;

  // R3
  no_bit_before_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    newbit_q |-> $past(active_q));

  // R3
  start_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> ($past(tick_i) && !$past(line_i)));

  // R4
  zero_is_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (newbit_q && !nrz_q) |-> (prev_q != $past(prev_q)));
endmodule

// File: rtl/lrx_destuff.sv
module lrx_destuff #(
  parameter int unsigned RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic newbit_i,
  input  logic nrz_i,
  output logic accept_o,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(RUN);

  logic [CW-1:0] ones_q;
  logic          pause;

  assign pause    = (ones_q == RUN_C);
  assign accept_o = newbit_i && !pause;
  assign bit_o    = nrz_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ones_q <= '0;
    else if (newbit_i) begin
      if (pause || !nrz_i) ones_q <= '0;
      else                 ones_q <= ones_q + 1'b1;
    end
  end

  // R6
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= RUN_C);

  // R6
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (newbit_i && pause) |=> (ones_q == '0));

  // R9
  zero_resets_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (newbit_i && !nrz_i) |=> (ones_q == '0));
endmodule

// File: rtl/lrx_byte_asm.sv
module lrx_byte_asm #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o,
  output logic         valid_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, byte_q, sh_next;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  assign sh_next = {bit_i, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept_i) begin
        sh_q <= sh_next;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          byte_q  <= sh_next;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;

  // R7
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R7
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(byte_q) |-> valid_q);

  // R5
  msb_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (byte_q[W-1] == $past(bit_i)));
endmodule

// File: rtl/lrx_deser.sv
module lrx_deser
  import lrx_pkg::*;
#(
  parameter int unsigned BYTE_W  = LRX_BYTE_W,
  parameter int unsigned RUN_LEN = LRX_RUN_LEN,
  parameter int unsigned DIV     = LRX_DIV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o
);
  logic tick, newbit, nrz, accept, acc_bit;

  lrx_tick_gen #(.DIV(DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  lrx_nrzi_dec i_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .line_i  (line_i),
    .newbit_o(newbit),
    .nrz_o   (nrz)
  );

  lrx_destuff #(.RUN(RUN_LEN)) i_destuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .newbit_i(newbit),
    .nrz_i   (nrz),
    .accept_o(accept),
    .bit_o   (acc_bit)
  );

  lrx_byte_asm #(.W(BYTE_W)) i_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .bit_i   (acc_bit),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |=> !byte_valid_o);
endmodule

// File: tb/test_lrx_deser.sv
module test_lrx_deser;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b1;
  logic [7:0] byte_o;
  logic       byte_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_buf[16];
  int tx_len = 0;
  logic prev_v = 1'b0;
  int dbl_strobe = 0;

  lrx_deser i_lrx_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && byte_valid_o) rx_q.push_back(byte_o);
    if (prev_v && byte_valid_o) dbl_strobe <= dbl_strobe + 1;
    prev_v <= byte_valid_o;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    line_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rx_q.delete();
    @(negedge clk_i);
  endtask

  task automatic drive(input logic v);
    line_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  // reference encoder: start bit, LSB-first, stuffing, NRZI
  task automatic send_stream(input int phase, input int tail_zeros);
    int   ones = 0;
    logic lvl  = 1'b1;
    line_i = 1'b1;
    repeat (8 + phase) @(negedge clk_i);
    lvl = ~lvl;
    drive(lvl);
    for (int i = 0; i < tx_len; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic d;
        d = tx_buf[i][b];
        if (!d) lvl = ~lvl;
        drive(lvl);
        if (d) begin
          ones++;
          if (ones == 6) begin
            lvl = ~lvl;
            drive(lvl);
            ones = 0;
          end
        end else ones = 0;
      end
    end
    for (int z = 0; z < tail_zeros; z++) begin
      lvl = ~lvl;
      drive(lvl);
    end
    repeat (8) @(negedge clk_i);
  endtask

  task automatic expect_rx(input string req);
    check(rx_q.size() == tx_len, req, rx_q.size(), tx_len);
    for (int i = 0; i < tx_len; i++)
      if (i < rx_q.size()) check(rx_q[i] == tx_buf[i], req, rx_q[i], tx_buf[i]);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(byte_o == 8'h00, "R1 byte in reset", byte_o, 0);
    check(byte_valid_o == 1'b0, "R1 valid in reset", byte_valid_o, 0);
    do_reset();
    check(byte_o == 8'h00 && !byte_valid_o, "R1 after release", byte_o, 0);
  endtask

  task automatic t_idle();
    do_reset();
    repeat (200) @(negedge clk_i);
    check(rx_q.size() == 0, "R2 idle high", rx_q.size(), 0);
  endtask

  task automatic t_single();
    do_reset();
    tx_buf[0] = 8'hA5; tx_len = 1;
    send_stream(0, 0);
    expect_rx("R3 R4 single byte");
    do_reset();
    tx_buf[0] = 8'h01; tx_len = 1;
    send_stream(1, 0);
    expect_rx("R5 lsb first");
  endtask

  task automatic t_stuff();
    do_reset();
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'h00; tx_buf[2] = 8'h3F; tx_buf[3] = 8'hFF;
    tx_buf[4] = 8'hFF; tx_buf[5] = 8'h81; tx_len = 6;
    send_stream(2, 0);
    expect_rx("R6 stuffed zero dropped");
  endtask

  task automatic t_five();
    do_reset();
    tx_buf[0] = 8'h1F; tx_buf[1] = 8'hDF; tx_len = 2;
    send_stream(3, 0);
    expect_rx("R9 zero after five ones");
  endtask

  task automatic t_hold();
    do_reset();
    tx_buf[0] = 8'h5A; tx_len = 1;
    send_stream(0, 4);
    expect_rx("R7 no strobe for partial byte");
    check(byte_o == 8'h5A, "R7 byte held", byte_o, 8'h5A);
  endtask

  task automatic t_phase();
    for (int p = 0; p < 4; p++) begin
      do_reset();
      tx_buf[0] = 8'h7E; tx_buf[1] = 8'hC3; tx_buf[2] = 8'hFE; tx_buf[3] = 8'h80;
      tx_len = 4;
      send_stream(p, 0);
      expect_rx("R8 symbol phase");
    end
  endtask

  task automatic finish_run();
    check(dbl_strobe == 0, "R7 single-clock strobe", dbl_strobe, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_stuff();
    t_five();
    t_hold();
    t_phase();
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule